// File: doc/BRIEF.md
# Frequency-Change Watchdog with Recovery Lock

This block guards software-initiated clock frequency changes. Software writes a new frequency setting; if the watchdog is enabled, that accepted write arms a countdown of a programmed number of prescaler ticks. If software does not disable the watchdog before the count runs out, the block declares a timeout. It sets a sticky status flag, loads a recovery frequency setting, and locks out further software frequency writes. If enabled, it also requests a system reset pulse. Clearing the enable bit releases the lock and returns the counter to idle.

The prescaler time base arrives as two single-cycle enable pulses, a short tick and a long tick. A one-bit select picks which of them drives the countdown. A separate enable requests the same reset pulse after every accepted frequency write, whether or not the watchdog is on. All pins are plain control and status levels or strobes. There is no streaming interface, so there is no back-pressure: a write strobe always takes effect in the cycle it is seen, unless the lock rejects it.

Top module: `freq_wdog`

## Requirements
- R1: After reset the frequency output equals the FREQ_INIT parameter (default 8'h10), the status and lock outputs are 0, and the active-low reset output is 1.
- R2: When unlocked, a frequency write strobe with data D makes the frequency output equal D from the next cycle on.
- R3: While the enable input is 0, the countdown is held idle and reloaded, and no timeout can occur no matter how many ticks or writes arrive.
- R4: With enable at 1, an accepted frequency write loads the 5-bit timeout value V. The timeout occurs on the (V+1)-th selected tick after that write, so V=0 gives 1 tick and V=31 gives 32 ticks.
- R5: Prescaler select 0 counts short ticks, and select 1 counts long ticks. Pulses on the unselected tick input do not advance the count.
- R6: On timeout, in the same clock edge, the status output becomes 1, the lock output becomes 1, and the frequency output takes the recovery frequency input.
- R7: The status bit is sticky. A status write with data 1 clears it, and a status write with data 0 leaves it unchanged. A timeout in the same cycle as a clearing write leaves it at 1.
- R8: While locked, frequency writes are ignored. The frequency is unchanged, the countdown does not restart, and no frequency-change reset is requested. Driving the enable input to 0 clears the lock on the next edge.
- R9: When the watchdog reset enable is 1, a timeout drives the reset output low for exactly RST_LEN cycles (default 16), starting the cycle after the timeout edge.
- R10: When the frequency-change reset enable is 1, every accepted frequency write drives the reset output low for RST_LEN cycles, whatever the watchdog enable is.
- R11: A reset request that arrives while a pulse is active extends it into one pulse that ends RST_LEN cycles after the newest request.
- R12: An accepted frequency write while the countdown runs reloads V, so the timeout is measured from the newest write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_short_i | input | 1 | Short prescaler tick, one-cycle pulse |
| tick_long_i | input | 1 | Long prescaler tick, one-cycle pulse |
| pre_sel_i | input | 1 | Tick select: 0 short, 1 long |
| tmo_val_i | input | TMO_W | Programmed timeout value V |
| wd_en_i | input | 1 | Watchdog enable; 0 stops, reloads and unlocks |
| rst_en_wd_i | input | 1 | Request reset pulse on timeout |
| rst_en_fc_i | input | 1 | Request reset pulse on each accepted frequency write |
| freq_wr_i | input | 1 | Software frequency write strobe |
| freq_wdata_i | input | FREQ_W | Software frequency setting |
| recov_freq_i | input | FREQ_W | Recovery frequency setting loaded on timeout |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wdata_i | input | 1 | Status write data (1 clears) |
| freq_o | output | FREQ_W | Active frequency setting |
| lock_o | output | 1 | Recovery lock active |
| sts_o | output | 1 | Sticky timeout status |
| sys_rst_n_o | output | 1 | Active-low system reset pulse |

## Verification
The embedded properties check on every cycle four behaviours: a disabled watchdog is idle and unlocked, a locked write leaves the frequency untouched, the status bit stays set until a clearing write, and a timeout sets the status, lock and recovery frequency on the same edge. Exact tick counts, the choice of prescaler input and the length and merging of reset pulses depend on whole scenarios, so only the bench can show them. The bench sweeps every timeout value under both prescaler settings, with decoy pulses on the unselected tick input, and measures pulse widths at the reset pin.

// File: rtl/freq_wdog_pkg.sv
package freq_wdog_pkg;
  typedef enum logic {
    WD_IDLE = 1'b0,
    WD_RUN  = 1'b1
  } wd_state_e;
endpackage

// File: rtl/wdog_countdown.sv
module wdog_countdown
  import freq_wdog_pkg::*;
#(
  parameter int TMO_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             arm_i,
  input  logic             tick_i,
  input  logic [TMO_W-1:0] load_i,
  output logic             expire_o,
  output logic             running_o
);
  wd_state_e        state_q;
  logic [TMO_W-1:0] cnt_q;

  assign expire_o  = (state_q == WD_RUN) && tick_i && (cnt_q == '0) && en_i && !arm_i;
  assign running_o = (state_q == WD_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WD_IDLE;
      cnt_q   <= '0;
    end else if (!en_i) begin
      state_q <= WD_IDLE;
      cnt_q   <= load_i;
    end else if (arm_i) begin
      state_q <= WD_RUN;
      cnt_q   <= load_i;
    end else if (state_q == WD_RUN && tick_i) begin
      if (cnt_q == '0) state_q <= WD_IDLE;
      else             cnt_q   <= cnt_q - 1'b1;
    end
  end

  // R3: a disabled watchdog is idle on the next edge
  p_idle_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !running_o);

  // R4: an expiry without re-arming stops the countdown
  p_stop_after_expire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !arm_i) |=> !running_o);
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen #(
  parameter int RST_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic rst_n_o
);
  localparam int CW = $clog2(RST_LEN + 1);
  localparam logic [CW-1:0] LEN_V = CW'(RST_LEN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (req_i)        cnt_q <= LEN_V;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign rst_n_o = (cnt_q == '0);

  // R9: any request drives the reset output low on the next cycle
  p_req_drives_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> !rst_n_o);

  // R11: a pulse never ends one cycle after a request
  p_no_early_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !rst_n_o) |=> !rst_n_o);
endmodule

// File: rtl/freq_guard.sv
module freq_guard #(
  parameter int              FREQ_W    = 8,
  parameter logic [FREQ_W-1:0] FREQ_INIT = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [FREQ_W-1:0] wdata_i,
  input  logic              expire_i,
  input  logic [FREQ_W-1:0] recov_i,
  output logic [FREQ_W-1:0] freq_o,
  output logic              lock_o,
  output logic              accept_o
);
  logic [FREQ_W-1:0] freq_q;
  logic              lock_q;

  assign accept_o = wr_i && !lock_q;
  assign freq_o   = freq_q;
  assign lock_o   = lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_q <= FREQ_INIT;
      lock_q <= 1'b0;
    end else begin
      if (expire_i)      freq_q <= recov_i;
      else if (accept_o) freq_q <= wdata_i;
      if (!en_i)         lock_q <= 1'b0;
      else if (expire_i) lock_q <= 1'b1;
    end
  end

  // R8: a write while locked leaves the frequency unchanged
  p_locked_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && wr_i && !expire_i) |=> $stable(freq_q));

  // R8: disabling releases the lock
  p_unlock_on_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !lock_o);
endmodule

// File: rtl/freq_wdog.sv
module freq_wdog #(
  parameter int              TMO_W     = 5,
  parameter int              FREQ_W    = 8,
  parameter int              RST_LEN   = 16,
  parameter logic [FREQ_W-1:0] FREQ_INIT = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_short_i,
  input  logic              tick_long_i,
  input  logic              pre_sel_i,
  input  logic [TMO_W-1:0]  tmo_val_i,
  input  logic              wd_en_i,
  input  logic              rst_en_wd_i,
  input  logic              rst_en_fc_i,
  input  logic              freq_wr_i,
  input  logic [FREQ_W-1:0] freq_wdata_i,
  input  logic [FREQ_W-1:0] recov_freq_i,
  input  logic              sts_wr_i,
  input  logic              sts_wdata_i,
  output logic [FREQ_W-1:0] freq_o,
  output logic              lock_o,
  output logic              sts_o,
  output logic              sys_rst_n_o
);
  logic tick_sel;
  logic accept;
  logic arm;
  logic expire;
  logic running;
  logic rst_req;
  logic sts_q;

  assign tick_sel = pre_sel_i ? tick_long_i : tick_short_i;
  assign arm      = accept && wd_en_i;
  assign rst_req  = (expire && rst_en_wd_i) || (accept && rst_en_fc_i);

  freq_guard #(.FREQ_W(FREQ_W), .FREQ_INIT(FREQ_INIT)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (wd_en_i),
    .wr_i     (freq_wr_i),
    .wdata_i  (freq_wdata_i),
    .expire_i (expire),
    .recov_i  (recov_freq_i),
    .freq_o   (freq_o),
    .lock_o   (lock_o),
    .accept_o (accept)
  );

  wdog_countdown #(.TMO_W(TMO_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (wd_en_i),
    .arm_i     (arm),
    .tick_i    (tick_sel),
    .load_i    (tmo_val_i),
    .expire_o  (expire),
    .running_o (running)
  );

  rst_pulse_gen #(.RST_LEN(RST_LEN)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (rst_req),
    .rst_n_o (sys_rst_n_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       sts_q <= 1'b0;
    else if (expire)                  sts_q <= 1'b1;
    else if (sts_wr_i && sts_wdata_i) sts_q <= 1'b0;
  end

  assign sts_o = sts_q;

  // R7: status stays set unless a clearing write arrives
  p_status_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q && !(sts_wr_i && sts_wdata_i)) |=> sts_q);

  // R6: a timeout sets status, lock and recovery frequency together
  p_expire_effects_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (sts_o && lock_o && freq_o == $past(recov_freq_i)));

  // R3: no timeout while the watchdog is idle
  p_no_expire_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !expire);
endmodule

// File: tb/freq_wdog_bench.sv
module freq_wdog_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_short_i = 0, tick_long_i = 0, pre_sel_i = 0;
  logic [4:0] tmo_val_i = '0;
  logic       wd_en_i = 0, rst_en_wd_i = 0, rst_en_fc_i = 0;
  logic       freq_wr_i = 0;
  logic [7:0] freq_wdata_i = '0;
  logic [7:0] recov_freq_i = 8'hA5;
  logic       sts_wr_i = 0, sts_wdata_i = 0;
  logic [7:0] freq_o;
  logic       lock_o, sts_o, sys_rst_n_o;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  freq_wdog u_freq_wdog (
    .clk(clk), .rst_n(rst_n), .tick_short_i(tick_short_i), .tick_long_i(tick_long_i),
    .pre_sel_i(pre_sel_i), .tmo_val_i(tmo_val_i), .wd_en_i(wd_en_i),
    .rst_en_wd_i(rst_en_wd_i), .rst_en_fc_i(rst_en_fc_i), .freq_wr_i(freq_wr_i),
    .freq_wdata_i(freq_wdata_i), .recov_freq_i(recov_freq_i), .sts_wr_i(sts_wr_i),
    .sts_wdata_i(sts_wdata_i), .freq_o(freq_o), .lock_o(lock_o), .sts_o(sts_o),
    .sys_rst_n_o(sys_rst_n_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr_freq(input logic [7:0] d);
    freq_wr_i = 1; freq_wdata_i = d; cyc(); freq_wr_i = 0;
  endtask

  task automatic clr_sts(input logic d);
    sts_wr_i = 1; sts_wdata_i = d; cyc(); sts_wr_i = 0;
  endtask

  task automatic tick(input logic long_t);
    if (long_t) tick_long_i = 1; else tick_short_i = 1;
    cyc(); tick_long_i = 0; tick_short_i = 0;
  endtask

  task automatic low_len(output int n);
    n = 0;
    while (!sys_rst_n_o && n < 100) begin n++; cyc(); end
  endtask

  initial begin
    #2000000;
    fails++; tests++;
    $display("FAIL watchdog: bench hung");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    cyc(); cyc(); rst_n = 1; cyc();
    // R1 reset state
    chk("R1 freq", freq_o, 8'h10);
    chk("R1 sts", sts_o, 0);
    chk("R1 lock", lock_o, 0);
    chk("R1 rst", sys_rst_n_o, 1);

    // R2 unlocked write
    wr_freq(8'h33);
    chk("R2 freq", freq_o, 8'h33);

    // R3 disabled: no timeout
    tmo_val_i = 0; wr_freq(8'h34);
    for (int i = 0; i < 40; i++) begin tick(0); tick(1); end
    chk("R3 sts", sts_o, 0);
    chk("R3 lock", lock_o, 0);

    // R4/R5/R6 sweep all values, both prescalers, decoy ticks
    for (int p = 0; p < 2; p++) begin
      for (int v = 0; v < 32; v++) begin
        int bad = 0;
        pre_sel_i = p[0]; tmo_val_i = v[4:0]; wd_en_i = 1; cyc();
        wr_freq(8'h40 + v[7:0]);
        for (int k = 1; k <= v + 1; k++) begin
          tick(!p[0]);
          tick(p[0]);
          if (sts_o != (k == v + 1)) bad++;
        end
        chk(p ? "R5 long-tick count" : "R4 short-tick count", bad, 0);
        chk("R6 recov freq", freq_o, 8'hA5);
        chk("R6 lock", lock_o, 1);
        wd_en_i = 0; cyc();
        clr_sts(1);
      end
    end

    // R7 sticky status and clear rules
    pre_sel_i = 0; tmo_val_i = 1; wd_en_i = 1; cyc(); wr_freq(8'h50);
    tick(0);
    sts_wr_i = 1; sts_wdata_i = 1; tick(0); sts_wr_i = 0;
    chk("R7 set beats clear", sts_o, 1);
    clr_sts(0);
    chk("R7 write 0 no effect", sts_o, 1);

    // R8 locked: writes ignored, no restart, no fc reset
    rst_en_fc_i = 1;
    wr_freq(8'h77);
    chk("R8 locked freq", freq_o, 8'hA5);
    chk("R8 no fc pulse", sys_rst_n_o, 1);
    chk("R8 still locked", lock_o, 1);
    clr_sts(1);
    chk("R7 write 1 clears", sts_o, 0);
    for (int i = 0; i < 5; i++) tick(0);
    chk("R8 no restart", sts_o, 0);
    wd_en_i = 0; cyc();
    chk("R8 unlock", lock_o, 0);

    // R10 fc reset with watchdog off
    wr_freq(8'h61);
    chk("R2 freq after unlock", freq_o, 8'h61);
    low_len(n);
    chk("R10 fc pulse len", n, 16);

    // R11 merge: second request 5 cycles into the pulse
    wr_freq(8'h62);
    n = 0;
    for (int i = 0; i < 4; i++) begin if (!sys_rst_n_o) n++; cyc(); end
    wr_freq(8'h63);
    chk("R11 low before merge", n, 4);
    low_len(n);
    chk("R11 merged tail", n, 16);
    rst_en_fc_i = 0;

    // R9 watchdog reset pulse
    rst_en_wd_i = 1; wd_en_i = 1; tmo_val_i = 2; cyc();
    wr_freq(8'h64);
    tick(0); tick(0);
    chk("R9 before expiry", sys_rst_n_o, 1);
    tick(0);
    chk("R9 expired", sts_o, 1);
    low_len(n);
    chk("R9 wd pulse len", n, 16);
    wd_en_i = 0; cyc(); clr_sts(1); rst_en_wd_i = 0;

    // R12 restart on new write
    wd_en_i = 1; tmo_val_i = 5; cyc();
    wr_freq(8'h65);
    for (int i = 0; i < 3; i++) tick(0);
    wr_freq(8'h66);
    for (int i = 0; i < 5; i++) tick(0);
    chk("R12 not yet", sts_o, 0);
    tick(0);
    chk("R12 expires at 6", sts_o, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule